// File: doc/BRIEF.md
# Shadow-Stack User Control Register with Access Gate

This block holds a 64-bit control register that configures a user-level shadow-stack feature, and decides, in the same cycle as each request, whether a system-register read or write to it may go ahead. A request carries a five-field encoding tuple, a read/write flag and the privilege level of the requester (0 to 3). A set of configuration inputs describes the machine: whether the feature exists, whether level 3 exists, whether level 2 is enabled, whether fine-grained trapping exists, the level 3 feature and fine-grained enables, two inputs that pick between an undefined result and a trap when level 3 blocks access, and one fine-grained trap bit for reads and one for writes.

Each matching request resolves to exactly one of four outcomes: undefined, trap to level 2, trap to level 3, or completed. Traps also return a syndrome class. Only five bits of the register hold state. The whole stored word is exported to the rest of the core, whose trap logic uses those bits.

Top module: `sysreg_guard_ctl`

## Requirements
- R1: A request is decoded only when op0=2'b11, op1=3'b000, CRn=4'b0010, CRm=4'b0101 and op2=3'b010, for both reads and writes; any other tuple gives rsp_vld=0, rsp_res=0 and leaves the register unchanged.
- R2: When the feature-present input is 0, or the requester level is 0, the outcome is undefined.
- R3: A request from level 3 with the feature present always completes.
- R4: At level 1, if level 3 exists, the undef-priority input is 1 and the level 3 feature enable is 0, the outcome is undefined, ahead of every other check.
- R5: At level 1, failing R4, if level 2 is enabled, fine-grained trapping exists, level 3 is absent or its fine-grained enable is 1, and the fine-grained trap bit for the request direction (read bit for reads, write bit for writes) is 0, the outcome is trap to level 2.
- R6: At level 1 (failing R4 and R5) and at level 2 (failing R4's condition), if level 3 exists and its feature enable is 0, the outcome is undefined when the undef-select input is 1 and trap to level 3 when it is 0; otherwise the request completes.
- R7: At level 2 the fine-grained step is never applied; a level 2 request never traps to level 2.
- R8: rsp_class is 6'h18 for either trap outcome and 0 for every other outcome.
- R9: rsp_res is one-hot while rsp_vld is 1, encoded bit 0 undefined, bit 1 trap to level 2, bit 2 trap to level 3, bit 3 completed, and is valid in the cycle of the request.
- R10: Only bits 10, 9, 8, 5 and 0 hold state; every other bit reads as 0 and ignores writes.
- R11: After reset the register is all zero.
- R12: The register changes only at the clock edge ending a completed write, taking the write data masked to the bits of R10; rsp_rdata is the register for a completed read and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_vld | input | 1 | Request strobe |
| req_wr | input | 1 | 1 write, 0 read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_lvl | input | 2 | Requester privilege level |
| req_wdata | input | 64 | Write data |
| cfg_feat | input | 1 | Feature present |
| cfg_has_l3 | input | 1 | Level 3 present |
| cfg_l2_on | input | 1 | Level 2 enabled |
| cfg_fgt | input | 1 | Fine-grained trapping present |
| cfg_l3_feat_en | input | 1 | Level 3 feature enable |
| cfg_l3_fgt_en | input | 1 | Level 3 fine-grained enable |
| cfg_undef_prio | input | 1 | Undefined takes priority when level 3 blocks |
| cfg_undef_sel | input | 1 | Level 3 block gives undefined instead of a trap |
| cfg_fg_rd_n | input | 1 | Fine-grained read trap bit (0 traps) |
| cfg_fg_wr_n | input | 1 | Fine-grained write trap bit (0 traps) |
| rsp_vld | output | 1 | Request decoded |
| rsp_res | output | 4 | One-hot outcome |
| rsp_class | output | 6 | Syndrome class |
| rsp_rdata | output | 64 | Read data |
| ctl_word | output | 64 | Stored register word |

## Verification
The decision chain is driven with random configuration vectors, levels and directions, so every combination of level 3 blocking, undef priority and fine-grained gating appears; this separates the priority order of the undefined and trap-to-level-2 checks and shows whether the read and write trap bits are swapped. Directed cases pin the level 0, level 3 and feature-absent paths, the undef-select choice, and level 2 requests with a clear fine-grained bit, which tell apart a chain that skips the fine-grained step from one that does not. Random write data with all bits set and tuples with one field disturbed show whether unimplemented bits or mismatched and refused writes reach the register.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

   typedef enum logic [1:0] {
      LVL_USER = 2'd0,
      LVL_OS   = 2'd1,
      LVL_HYP  = 2'd2,
      LVL_MON  = 2'd3
   } priv_lvl_e;

   // One-hot outcome; undef is bit 0, done is bit 3
   typedef struct packed {
      logic done;
      logic trap_l3;
      logic trap_l2;
      logic undef;
   } verdict_t;

   typedef struct packed {
      logic feat;
      logic has_l3;
      logic l2_on;
      logic fgt;
      logic l3_feat_en;
      logic l3_fgt_en;
      logic undef_prio;
      logic undef_sel;
      logic fg_rd_n;
      logic fg_wr_n;
   } gate_cfg_t;

endpackage

// File: rtl/sgc_decode.sv
module sgc_decode #(
   parameter logic [1:0] OP0 = 2'b11,
   parameter logic [2:0] OP1 = 3'b000,
   parameter logic [3:0] CRN = 4'b0010,
   parameter logic [3:0] CRM = 4'b0101,
   parameter logic [2:0] OP2 = 3'b010
) (
   input  logic       vld,
   input  logic [1:0] op0,
   input  logic [2:0] op1,
   input  logic [3:0] crn,
   input  logic [3:0] crm,
   input  logic [2:0] op2,
   output logic       hit
);
   localparam int KEY_W = 16;
   localparam logic [KEY_W-1:0] KEY = {OP0, OP1, CRN, CRM, OP2};

   logic [KEY_W-1:0] req_key;

   assign req_key = {op0, op1, crn, crm, op2};
   assign hit     = vld && (req_key == KEY);
endmodule

// File: rtl/sgc_arbiter.sv
module sgc_arbiter
   import sgc_pkg::*;
#(
   parameter int          CLASS_W     = 6,
   parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18,
   parameter bit          FGT_STEP_EN = 1'b1
) (
   input  logic               hit,
   input  logic               wr,
   input  priv_lvl_e          lvl,
   input  gate_cfg_t          cfg,
   output verdict_t           verdict,
   output logic [CLASS_W-1:0] cls
);
   logic fgt_gate;
   logic l3_block;
   logic dir_bit;
   logic fgt_hit;

   generate
      if (FGT_STEP_EN) begin : g_fgt_on
         assign fgt_gate = 1'b1;
      end else begin : g_fgt_off
         assign fgt_gate = 1'b0;
      end
   endgenerate

   assign l3_block = cfg.has_l3 && !cfg.l3_feat_en;
   assign dir_bit  = wr ? cfg.fg_wr_n : cfg.fg_rd_n;
   assign fgt_hit  = fgt_gate && cfg.l2_on && cfg.fgt &&
                     (!cfg.has_l3 || cfg.l3_fgt_en) && !dir_bit;

   always_comb begin
      verdict = '0;
      if (hit) begin
         if (!cfg.feat) begin
            verdict.undef = 1'b1;
         end else begin
            unique case (lvl)
               LVL_USER: verdict.undef = 1'b1;
               LVL_OS: begin
                  if (l3_block && cfg.undef_prio)  verdict.undef   = 1'b1;
                  else if (fgt_hit)                 verdict.trap_l2 = 1'b1;
                  else if (l3_block && cfg.undef_sel) verdict.undef = 1'b1;
                  else if (l3_block)                verdict.trap_l3 = 1'b1;
                  else                              verdict.done    = 1'b1;
               end
               LVL_HYP: begin
                  if (l3_block && cfg.undef_prio)  verdict.undef   = 1'b1;
                  else if (l3_block && cfg.undef_sel) verdict.undef = 1'b1;
                  else if (l3_block)                verdict.trap_l3 = 1'b1;
                  else                              verdict.done    = 1'b1;
               end
               default: verdict.done = 1'b1;
            endcase
         end
      end
   end

   assign cls = (verdict.trap_l2 || verdict.trap_l3) ? TRAP_CLASS : '0;
endmodule

// File: rtl/sgc_store.sv
module sgc_store #(
   parameter int                DATA_W    = 64,
   parameter logic [DATA_W-1:0] IMPL_MASK = 64'h721
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              re,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] rdata
);
   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         if (IMPL_MASK[b]) begin : g_impl
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)  bit_q <= 1'b0;
               else if (we) bit_q <= wdata[b];
            end
            assign word[b] = bit_q;
         end else begin : g_tie
            assign word[b] = 1'b0;
         end
      end
   endgenerate

   assign rdata = re ? word : '0;
endmodule

// File: rtl/sysreg_guard_ctl.sv
module sysreg_guard_ctl
   import sgc_pkg::*;
#(
   parameter int                 DATA_W      = 64,
   parameter logic [DATA_W-1:0]  IMPL_MASK   = 64'h721,
   parameter int                 CLASS_W     = 6,
   parameter logic [CLASS_W-1:0] TRAP_CLASS  = 6'h18,
   parameter bit                 FGT_STEP_EN = 1'b1,
   parameter logic [1:0]         OP0 = 2'b11,
   parameter logic [2:0]         OP1 = 3'b000,
   parameter logic [3:0]         CRN = 4'b0010,
   parameter logic [3:0]         CRM = 4'b0101,
   parameter logic [2:0]         OP2 = 3'b010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_vld,
   input  logic               req_wr,
   input  logic [1:0]         req_op0,
   input  logic [2:0]         req_op1,
   input  logic [3:0]         req_crn,
   input  logic [3:0]         req_crm,
   input  logic [2:0]         req_op2,
   input  logic [1:0]         req_lvl,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic               cfg_feat,
   input  logic               cfg_has_l3,
   input  logic               cfg_l2_on,
   input  logic               cfg_fgt,
   input  logic               cfg_l3_feat_en,
   input  logic               cfg_l3_fgt_en,
   input  logic               cfg_undef_prio,
   input  logic               cfg_undef_sel,
   input  logic               cfg_fg_rd_n,
   input  logic               cfg_fg_wr_n,
   output logic               rsp_vld,
   output logic [3:0]         rsp_res,
   output logic [CLASS_W-1:0] rsp_class,
   output logic [DATA_W-1:0]  rsp_rdata,
   output logic [DATA_W-1:0]  ctl_word
);
   generate
      if (DATA_W < 11) begin : g_bad_width
         $error("DATA_W must hold bit 10");
      end
      if (IMPL_MASK == '0) begin : g_bad_mask
         $error("IMPL_MASK must keep at least one bit");
      end
      if (CLASS_W < 5) begin : g_bad_class
         $error("CLASS_W too narrow for the trap class");
      end
   endgenerate

   logic      hit;
   gate_cfg_t cfg;
   verdict_t  verdict;

   assign cfg = '{feat:       cfg_feat,
                  has_l3:     cfg_has_l3,
                  l2_on:      cfg_l2_on,
                  fgt:        cfg_fgt,
                  l3_feat_en: cfg_l3_feat_en,
                  l3_fgt_en:  cfg_l3_fgt_en,
                  undef_prio: cfg_undef_prio,
                  undef_sel:  cfg_undef_sel,
                  fg_rd_n:    cfg_fg_rd_n,
                  fg_wr_n:    cfg_fg_wr_n};

   sgc_decode #(
      .OP0(OP0), .OP1(OP1), .CRN(CRN), .CRM(CRM), .OP2(OP2)
   ) u_dec (
      .vld (req_vld),
      .op0 (req_op0),
      .op1 (req_op1),
      .crn (req_crn),
      .crm (req_crm),
      .op2 (req_op2),
      .hit (hit)
   );

   sgc_arbiter #(
      .CLASS_W(CLASS_W), .TRAP_CLASS(TRAP_CLASS), .FGT_STEP_EN(FGT_STEP_EN)
   ) u_arb (
      .hit     (hit),
      .wr      (req_wr),
      .lvl     (priv_lvl_e'(req_lvl)),
      .cfg     (cfg),
      .verdict (verdict),
      .cls     (rsp_class)
   );

   sgc_store #(
      .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (verdict.done && req_wr),
      .re    (verdict.done && !req_wr),
      .wdata (req_wdata),
      .word  (ctl_word),
      .rdata (rsp_rdata)
   );

   assign rsp_vld = hit;
   assign rsp_res = verdict;
endmodule

// File: rtl/sgc_checker.sv
module sgc_checker #(
   parameter int                 DATA_W     = 64,
   parameter logic [DATA_W-1:0]  IMPL_MASK  = 64'h721,
   parameter int                 CLASS_W    = 6,
   parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_wr,
   input logic [1:0]         req_lvl,
   input logic [DATA_W-1:0]  req_wdata,
   input logic               cfg_feat,
   input logic               cfg_has_l3,
   input logic               cfg_l3_feat_en,
   input logic               cfg_undef_prio,
   input logic               rsp_vld,
   input logic [3:0]         rsp_res,
   input logic [CLASS_W-1:0] rsp_class,
   input logic [DATA_W-1:0]  rsp_rdata,
   input logic [DATA_W-1:0]  ctl_word
);
   logic wr_done;
   logic rd_done;
   assign wr_done = rsp_vld && req_wr && rsp_res[3];
   assign rd_done = rsp_vld && !req_wr && rsp_res[3];

   assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_vld |-> rsp_res == 4'b0000);

   assert_user_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && (!cfg_feat || req_lvl == 2'd0)) |-> rsp_res == 4'b0001);

   assert_mon_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && cfg_feat && req_lvl == 2'd3) |-> rsp_res == 4'b1000);

   assert_prio_undef_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && cfg_feat && req_lvl == 2'd1 && cfg_has_l3 &&
       cfg_undef_prio && !cfg_l3_feat_en) |-> rsp_res == 4'b0001);

   assert_hyp_no_fg_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && req_lvl == 2'd2) |-> !rsp_res[1]);

   assert_trap_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_res[1] || rsp_res[2]) |-> rsp_class == TRAP_CLASS);

   assert_other_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_res[1] || rsp_res[2]) |-> rsp_class == '0);

   assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld |-> $countones(rsp_res) == 1);

   assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_word & ~IMPL_MASK) == '0);

   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_done |=> $stable(ctl_word));

   assert_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> ctl_word == ($past(req_wdata) & IMPL_MASK));

   assert_rdata_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_done |-> rsp_rdata == '0);
endmodule

bind sysreg_guard_ctl sgc_checker #(
   .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK),
   .CLASS_W(CLASS_W), .TRAP_CLASS(TRAP_CLASS)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_wr         (req_wr),
   .req_lvl        (req_lvl),
   .req_wdata      (req_wdata),
   .cfg_feat       (cfg_feat),
   .cfg_has_l3     (cfg_has_l3),
   .cfg_l3_feat_en (cfg_l3_feat_en),
   .cfg_undef_prio (cfg_undef_prio),
   .rsp_vld        (rsp_vld),
   .rsp_res        (rsp_res),
   .rsp_class      (rsp_class),
   .rsp_rdata      (rsp_rdata),
   .ctl_word       (ctl_word)
);

// File: tb/sim_sysreg_guard_ctl.sv
module sim_sysreg_guard_ctl;
   localparam logic [63:0] MASK = 64'h721;
   // cfg vector bit positions
   localparam int C_FEAT = 0, C_L3 = 1, C_L2ON = 2, C_FGT = 3, C_L3EN = 4;
   localparam int C_L3FG = 5, C_PRIO = 6, C_SEL = 7, C_FGRD = 8, C_FGWR = 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0, req_wr = 1'b0;
   logic [1:0]  req_op0 = 2'b11;
   logic [2:0]  req_op1 = 3'b000;
   logic [3:0]  req_crn = 4'b0010, req_crm = 4'b0101;
   logic [2:0]  req_op2 = 3'b010;
   logic [1:0]  req_lvl = 2'd0;
   logic [63:0] req_wdata = '0;
   logic [9:0]  cfg = '0;
   logic        rsp_vld;
   logic [3:0]  rsp_res;
   logic [5:0]  rsp_class;
   logic [63:0] rsp_rdata, ctl_word;

   int n_chk = 0, n_err = 0;
   logic [63:0] model = '0;
   bit done_flag = 1'b0;

   always #4 clk = ~clk;

   sysreg_guard_ctl u0 (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
      .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn),
      .req_crm(req_crm), .req_op2(req_op2), .req_lvl(req_lvl),
      .req_wdata(req_wdata),
      .cfg_feat(cfg[C_FEAT]), .cfg_has_l3(cfg[C_L3]), .cfg_l2_on(cfg[C_L2ON]),
      .cfg_fgt(cfg[C_FGT]), .cfg_l3_feat_en(cfg[C_L3EN]),
      .cfg_l3_fgt_en(cfg[C_L3FG]), .cfg_undef_prio(cfg[C_PRIO]),
      .cfg_undef_sel(cfg[C_SEL]), .cfg_fg_rd_n(cfg[C_FGRD]),
      .cfg_fg_wr_n(cfg[C_FGWR]),
      .rsp_vld(rsp_vld), .rsp_res(rsp_res), .rsp_class(rsp_class),
      .rsp_rdata(rsp_rdata), .ctl_word(ctl_word)
   );

   // Expected outcome: bit0 undef, bit1 trap2, bit2 trap3, bit3 done
   function automatic logic [3:0] ref_res(input logic [9:0] c, input logic [1:0] lvl,
                                          input logic wr, output string tag);
      logic blk, fg;
      blk = c[C_L3] && !c[C_L3EN];
      fg  = c[C_L2ON] && c[C_FGT] && (!c[C_L3] || c[C_L3FG]) &&
            !(wr ? c[C_FGWR] : c[C_FGRD]);
      if (!c[C_FEAT] || lvl == 2'd0) begin tag = "R2"; return 4'b0001; end
      if (lvl == 2'd3) begin tag = "R3"; return 4'b1000; end
      if (blk && c[C_PRIO]) begin tag = "R4"; return 4'b0001; end
      if (lvl == 2'd1 && fg) begin tag = "R5"; return 4'b0010; end
      tag = (lvl == 2'd2) ? "R7" : "R6";
      if (blk) return c[C_SEL] ? 4'b0001 : 4'b0100;
      return 4'b1000;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Issue one request at negedge, check mid-cycle, let the edge pass
   task automatic issue(input logic match, input logic wr, input logic [1:0] lvl,
                        input logic [63:0] wd, input string force_tag);
      logic [3:0] er;
      string tag;
      @(negedge clk);
      req_vld = 1'b1; req_wr = wr; req_lvl = lvl; req_wdata = wd;
      {req_op0, req_op1, req_crn, req_crm, req_op2} = {2'b11, 3'b000, 4'b0010, 4'b0101, 3'b010};
      if (!match) req_crm = 4'b0100;
      #1;
      er = match ? ref_res(cfg, lvl, wr, tag) : 4'b0000;
      if (!match) tag = "R1";
      if (force_tag != "") tag = force_tag;
      chk({tag, " stored word before"}, ctl_word, model);
      chk({tag, " vld"}, {63'd0, rsp_vld}, {63'd0, match});
      chk({tag, " outcome R9"}, {60'd0, rsp_res}, {60'd0, er});
      chk({tag, " class R8"}, {58'd0, rsp_class}, (er[1] || er[2]) ? 64'h18 : 64'h0);
      chk({tag, " rdata R12"}, rsp_rdata, (er[3] && !wr) ? model : 64'h0);
      @(posedge clk);
      #1;
      if (er[3] && wr) model = wd & MASK;
      req_vld = 1'b0;
      chk({tag, " stored word after R12"}, ctl_word, model);
   endtask

   initial begin
      #(8 * 150000);
      if (!done_flag) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd1234);
      repeat (3) @(posedge clk);
      #1;
      chk("R11 reset word", ctl_word, 64'h0);
      chk("R11 reset vld", {63'd0, rsp_vld}, 64'h0);
      @(negedge clk); rst_n = 1'b1;

      // Directed cases
      cfg = '0; cfg[C_FEAT] = 1'b1;
      issue(1'b1, 1'b1, 2'd3, '1, "R10");             // all-ones write keeps 0x721
      issue(1'b1, 1'b0, 2'd3, '0, "R10");             // read back
      issue(1'b0, 1'b1, 2'd3, 64'h0, "R1");           // mismatched tuple ignored
      issue(1'b1, 1'b1, 2'd0, 64'h0, "R2");           // level 0 undefined, no write
      cfg[C_FEAT] = 1'b0;
      issue(1'b1, 1'b0, 2'd3, '0, "R2");              // feature absent
      cfg = '0; cfg[C_FEAT] = 1'b1; cfg[C_L3] = 1'b1; cfg[C_PRIO] = 1'b1;
      cfg[C_L2ON] = 1'b1; cfg[C_FGT] = 1'b1; cfg[C_L3FG] = 1'b1;
      issue(1'b1, 1'b1, 2'd1, 64'h0, "R4");           // priority undef beats fg trap
      cfg[C_L3EN] = 1'b1; cfg[C_FGRD] = 1'b1; cfg[C_FGWR] = 1'b0;
      issue(1'b1, 1'b0, 2'd1, '0, "R5");              // read bit set: completes
      issue(1'b1, 1'b1, 2'd1, 64'h0, "R5");           // write bit clear: trap 2
      issue(1'b1, 1'b1, 2'd2, 64'h20, "R7");          // level 2 skips fg step
      cfg[C_L3EN] = 1'b0; cfg[C_PRIO] = 1'b0; cfg[C_L2ON] = 1'b0;
      cfg[C_SEL] = 1'b1;
      issue(1'b1, 1'b0, 2'd1, '0, "R6");              // blocked, select undef
      cfg[C_SEL] = 1'b0;
      issue(1'b1, 1'b1, 2'd2, 64'h0, "R6");           // blocked, trap 3, no write
      issue(1'b1, 1'b1, 2'd3, 64'h0, "R3");

      // Random mix
      for (int i = 0; i < 600; i++) begin
         logic m;
         cfg = 10'($urandom);
         if (($urandom % 4) != 0) cfg[C_FEAT] = 1'b1;
         m = (($urandom % 6) != 0);
         issue(m, 1'($urandom), 2'($urandom), {$urandom, $urandom}, "");
      end

      done_flag = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule